// File: doc/BRIEF.md
# Page write buffer and timer

This block sits between a serial memory's bus controller and its storage array. A write command opens with a start address. Each data byte the controller receives is then parked in a small page buffer. The entry a byte lands in is picked by the low bits of a running address pointer, while the pointer's upper bits (the page number) stay fixed for the whole command. Once the page buffer has wrapped, later bytes replace the entries they land on. No byte reaches the array while the command is still arriving.

When the bus STOP arrives after at least one data byte, the block starts a self-timed write cycle. During the first cycles of that window it copies every buffer entry written in this command into the array, one entry per clock, all within the same page. It holds `busy` high for the full programmed cycle count, and the bus controller uses `busy` to withhold acknowledges. A write-protect input, sampled at STOP, suppresses the array writes without changing the timing. The shared address pointer is left one past the last byte written, wrapped within the page, so that a following current-address read continues from there.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy` is 0, `arr_we` is 0 and `addr_ptr` is 0.
- R2: A command with one data byte, ended by STOP, writes that byte to the start address. Afterwards `addr_ptr` equals the start address plus one.
- R3: Each accepted data byte advances only the low PAGE_BITS bits of the pointer, which wrap to zero. The upper bits never change within a command. For example, bytes at start address 0x3E go to 0x3E, 0x3F and then 0x38.
- R4: When more than 2**PAGE_BITS bytes arrive in one command, a later byte replaces the earlier byte at the same in-page position. The commit then makes exactly 2**PAGE_BITS array writes, each holding the latest byte for its location.
- R5: Only locations that received a byte in the current command are written. All other locations of the page keep their contents.
- R6: A STOP after a command with no data bytes does not raise `busy` and causes no array write.
- R7: `busy` rises in the cycle after STOP is sampled and stays high for exactly WR_CYCLES clock cycles. Every `arr_we` pulse falls inside that window.
- R8: If `write_protect` is 1 when STOP is sampled, the cycle produces no array write. `busy` still lasts WR_CYCLES cycles, and the pointer still ends at the last address plus one.
- R9: While `busy` is high, `cmd_begin`, `data_strobe` and `bus_stop` are ignored. The pointer and the array are left unchanged, and no new command opens.
- R10: `data_strobe` and `bus_stop` outside an open command are ignored: no `busy`, no write, no pointer change. A command opens with `cmd_begin` and closes with `bus_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_begin | input | 1 | Opens a write command; loads the pointer from `cmd_addr` |
| cmd_addr | input | ADDR_W | Start address of the command |
| data_strobe | input | 1 | One received data byte is present on `data_byte` |
| data_byte | input | DATA_W | Data byte to buffer |
| bus_stop | input | 1 | Bus STOP seen; closes the command |
| write_protect | input | 1 | High blocks array writes of the coming commit |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| addr_ptr | output | ADDR_W | Shared address pointer |

## Verification
A wrong entry index or valid mask shows up at the array port within the first 2**PAGE_BITS cycles after STOP. It appears as a byte at the wrong address, a missing write or an extra write into the page, and a shadow array in the bench that is compared location by location exposes it. A pointer that carries into the page bits shows up on `addr_ptr` one cycle after the offending byte. Timer errors change the number of cycles `busy` stays high, and counting those cycles against WR_CYCLES catches an error of a single cycle. Leaked acceptance while busy shows up as a changed pointer or a second busy period once the first one ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic {
      PH_IDLE   = 1'b0,
      PH_COMMIT = 1'b1
   } pwb_phase_e;
endpackage

// File: rtl/pwb_addr.sv
module pwb_addr #(
   parameter int ADDR_W    = 8,
   parameter int PAGE_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   localparam int HI_W = ADDR_W - PAGE_BITS;

   logic [PAGE_BITS-1:0] low_nxt;
   assign low_nxt = ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_addr;
      else if (step)
         ptr <= {ptr[ADDR_W-1:PAGE_BITS], low_nxt};
   end

   // R3: a byte step never moves the page number
   p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS])));

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = '0;
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [PAGE_BITS-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [PAGE_BITS-1:0] rd_idx,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 rd_valid,
   output logic                 any_valid
);
   localparam int ENTRIES = 1 << PAGE_BITS;

   logic [DATA_W-1:0]  ent [ENTRIES];
   logic [ENTRIES-1:0] mask;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      logic hit;
      assign hit = wr && (wr_idx == PAGE_BITS'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[g] <= '0;
         else if (hit)
            ent[g] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask[g] <= 1'b0;
         else if (clr)
            mask[g] <= 1'b0;
         else if (hit)
            mask[g] <= 1'b1;
      end
   end

   assign rd_data   = ent[rd_idx];
   assign rd_valid  = mask[rd_idx];
   assign any_valid = |mask;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
   import pwb_pkg::*;
#(
   parameter int WR_CYCLES = 1000000,
   parameter int PAGE_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic                 busy,
   output logic                 sweep_on,
   output logic [PAGE_BITS-1:0] sweep_idx,
   output logic                 done
);
   localparam int CW = $clog2(WR_CYCLES + 1);
   localparam logic [CW-1:0] LAST    = CW'(WR_CYCLES - 1);
   localparam logic [CW-1:0] ENTRY_N = CW'(1 << PAGE_BITS);

   pwb_phase_e       phase;
   logic [CW-1:0]    cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            phase <= PH_COMMIT;
            cnt   <= '0;
         end
      end else if (cnt == LAST) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   assign busy      = (phase == PH_COMMIT);
   assign done      = busy && (cnt == LAST);
   assign sweep_on  = busy && (cnt < ENTRY_N);
   assign sweep_idx = cnt[PAGE_BITS-1:0];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 3,
   parameter int WR_CYCLES = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_begin,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              data_strobe,
   input  logic [DATA_W-1:0] data_byte,
   input  logic              bus_stop,
   input  logic              write_protect,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              busy,
   output logic [ADDR_W-1:0] addr_ptr
);
   localparam int ENTRIES = 1 << PAGE_BITS;

   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must lie in 1..ADDR_W-1");
   end
   if (WR_CYCLES < ENTRIES) begin : g_bad_cycles
      $error("WR_CYCLES must cover one cycle per buffer entry");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic                 cmd_open;
   logic                 wp_lat;
   logic                 take_begin, take_byte, take_stop, start;
   logic                 sweep_on, done, ent_valid, any_valid;
   logic [PAGE_BITS-1:0] sweep_idx;

   assign take_begin = cmd_begin && !busy;
   assign take_byte  = data_strobe && cmd_open && !busy && !cmd_begin;
   assign take_stop  = bus_stop && cmd_open && !busy && !cmd_begin;
   assign start      = take_stop && any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_open <= 1'b0;
         wp_lat   <= 1'b0;
      end else begin
         if (take_begin)
            cmd_open <= 1'b1;
         else if (take_stop)
            cmd_open <= 1'b0;
         if (start)
            wp_lat <= write_protect;
      end
   end

   pwb_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take_begin),
      .load_addr (cmd_addr),
      .step      (take_byte),
      .ptr       (addr_ptr)
   );

   pwb_buffer #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (take_begin || done),
      .wr        (take_byte),
      .wr_idx    (addr_ptr[PAGE_BITS-1:0]),
      .wr_data   (data_byte),
      .rd_idx    (sweep_idx),
      .rd_data   (arr_wdata),
      .rd_valid  (ent_valid),
      .any_valid (any_valid)
   );

   pwb_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BITS(PAGE_BITS)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy),
      .sweep_on  (sweep_on),
      .sweep_idx (sweep_idx),
      .done      (done)
   );

   assign arr_we   = sweep_on && ent_valid && !wp_lat;
   assign arr_addr = {addr_ptr[ADDR_W-1:PAGE_BITS], sweep_idx};

   // R7: array writes only inside the timed window
   p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R8: a protected cycle never touches the array
   p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wp_lat) |-> !arr_we);

   // R6: the cycle starts only with buffered data
   p_busy_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && take_stop && !any_valid) |=> !busy);

   // R9: the pointer is frozen throughout a write cycle
   p_ptr_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_ptr));
endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int PB = 3;
   localparam int WR = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_begin = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic          data_strobe = 1'b0;
   logic [DW-1:0] data_byte = '0;
   logic          bus_stop = 1'b0;
   logic          write_protect = 1'b0;
   logic          arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;
   logic          busy;
   logic [AW-1:0] addr_ptr;

   int checks = 0;
   int fails  = 0;
   int wcount = 0;
   bit finished = 0;
   logic [DW-1:0] shadow [256];

   always #5 clk = ~clk;

   page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .WR_CYCLES(WR)) u_page_write_buffer (
      .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_addr(cmd_addr),
      .data_strobe(data_strobe), .data_byte(data_byte), .bus_stop(bus_stop),
      .write_protect(write_protect), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .busy(busy), .addr_ptr(addr_ptr)
   );

   always @(negedge clk) begin
      if (arr_we) begin
         shadow[arr_addr] <= arr_wdata;
         wcount <= wcount + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_begin(input logic [AW-1:0] a);
      @(negedge clk); cmd_begin = 1'b1; cmd_addr = a;
      @(negedge clk); cmd_begin = 1'b0;
   endtask

   task automatic do_byte(input logic [DW-1:0] d);
      @(negedge clk); data_strobe = 1'b1; data_byte = d;
      @(negedge clk); data_strobe = 1'b0;
   endtask

   task automatic do_stop;
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
      chk(addr_ptr == 8'h00, "R1 addr_ptr", int'(addr_ptr), 0);
   endtask

   task automatic t_single;
      int n;
      wcount = 0;
      do_begin(8'h25); do_byte(8'hA1); do_stop;
      wait_idle(n);
      chk(n == WR, "R7 busy length", n, WR);
      chk(shadow[8'h25] == 8'hA1, "R2 data", int'(shadow[8'h25]), 'hA1);
      chk(wcount == 1, "R2 write count", wcount, 1);
      chk(addr_ptr == 8'h26, "R2 pointer", int'(addr_ptr), 'h26);
   endtask

   task automatic t_wrap;
      int n;
      wcount = 0;
      do_begin(8'h3E); do_byte(8'hD0); do_byte(8'hD1); do_byte(8'hD2);
      chk(addr_ptr == 8'h39, "R3 pointer wrap", int'(addr_ptr), 'h39);
      do_stop;
      wait_idle(n);
      chk(shadow[8'h3E] == 8'hD0, "R3 at 3E", int'(shadow[8'h3E]), 'hD0);
      chk(shadow[8'h3F] == 8'hD1, "R3 at 3F", int'(shadow[8'h3F]), 'hD1);
      chk(shadow[8'h38] == 8'hD2, "R3 at 38", int'(shadow[8'h38]), 'hD2);
      chk(shadow[8'h40] == 8'hEE, "R3 next page untouched", int'(shadow[8'h40]), 'hEE);
      chk(wcount == 3, "R3 write count", wcount, 3);
   endtask

   task automatic t_overflow;
      int n;
      wcount = 0;
      do_begin(8'h40);
      for (int i = 0; i < 10; i++) do_byte(8'hB0 + 8'(i));
      do_stop;
      wait_idle(n);
      chk(shadow[8'h40] == 8'hB8, "R4 entry 0 replaced", int'(shadow[8'h40]), 'hB8);
      chk(shadow[8'h41] == 8'hB9, "R4 entry 1 replaced", int'(shadow[8'h41]), 'hB9);
      for (int i = 2; i < 8; i++)
         chk(shadow[8'h40 + 8'(i)] == 8'hB0 + 8'(i), "R4 kept entry",
             int'(shadow[8'h40 + 8'(i)]), 'hB0 + i);
      chk(wcount == 8, "R4 write count", wcount, 8);
      chk(addr_ptr == 8'h42, "R4 pointer", int'(addr_ptr), 'h42);
   endtask

   task automatic t_partial;
      int n;
      wcount = 0;
      do_begin(8'h10); do_byte(8'hC1); do_byte(8'hC2); do_stop;
      wait_idle(n);
      chk(shadow[8'h10] == 8'hC1 && shadow[8'h11] == 8'hC2, "R5 written pair",
          int'({shadow[8'h10], shadow[8'h11]}), 'hC1C2);
      chk(shadow[8'h12] == 8'hEE && shadow[8'h17] == 8'hEE, "R5 rest untouched",
          int'({shadow[8'h12], shadow[8'h17]}), 'hEEEE);
      chk(wcount == 2, "R5 write count", wcount, 2);
   endtask

   task automatic t_empty_stop;
      wcount = 0;
      do_begin(8'h70); do_stop;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R6 no busy", int'(busy), 0);
      chk(wcount == 0, "R6 no write", wcount, 0);
   endtask

   task automatic t_protect;
      int n;
      wcount = 0;
      write_protect = 1'b1;
      do_begin(8'h60); do_byte(8'hF0); do_stop;
      write_protect = 1'b0;
      wait_idle(n);
      chk(n == WR, "R8 busy length", n, WR);
      chk(wcount == 0, "R8 no write", wcount, 0);
      chk(shadow[8'h60] == 8'hEE, "R8 location kept", int'(shadow[8'h60]), 'hEE);
      chk(addr_ptr == 8'h61, "R8 pointer", int'(addr_ptr), 'h61);
   endtask

   task automatic t_busy_ignore;
      int n;
      wcount = 0;
      do_begin(8'h80); do_byte(8'h5A); do_stop;
      do_begin(8'h90); do_byte(8'h55); do_stop;
      wait_idle(n);
      chk(addr_ptr == 8'h81, "R9 pointer kept", int'(addr_ptr), 'h81);
      chk(shadow[8'h90] == 8'hEE, "R9 no stray write", int'(shadow[8'h90]), 'hEE);
      chk(wcount == 1, "R9 write count", wcount, 1);
      do_stop;
      chk(busy == 1'b0, "R9 no command opened", int'(busy), 0);
   endtask

   task automatic t_closed;
      wcount = 0;
      do_byte(8'h77); do_stop;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R10 no busy", int'(busy), 0);
      chk(addr_ptr == 8'h81, "R10 pointer kept", int'(addr_ptr), 'h81);
      chk(wcount == 0, "R10 no write", wcount, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) shadow[i] = 8'hEE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_single;
      t_wrap;
      t_overflow;
      t_partial;
      t_empty_stop;
      t_protect;
      t_busy_ignore;
      t_closed;
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule